// File: doc/BRIEF.md
# SD host interrupt status controller

This block keeps the interrupt status and mask state of a memory-card host controller. Single-cycle event pulses from the command, data and card-detect logic elsewhere in the host set sticky status bits. Each bit stays set until software clears it. A single interrupt line goes high while any status bit that can raise an interrupt is set and not masked.

Software reaches the 32-bit status and mask registers through a 16-bit register port. Each register is split into a low half and a high half, and each half is addressed on its own. A status bit is acknowledged by writing 0 to its position; a 1 written to a position leaves that bit alone. Two status positions are not events but live levels sampled at the moment of the read: the card write-protect state and the command-busy flag.

Status bit map: bits 0..9 hold command response end, command timeout, CRC failure, data end, data timeout, receive ready, transmit request, receive overflow, transmit underrun and illegal access. These are driven by event inputs 0..9 in that order. Bit 16 holds card removal and bit 17 holds card insertion, driven by event inputs 10 and 11. Bit 18 is the live write-protect level and bit 19 is the live command-busy level. All other status bits read 0.

Top module: `sdirq_ctrl`

## Requirements
- R1: After reset the status register reads 0, both mask halves read 0xFFFF, and irq_o is low.
- R2: A one-cycle pulse on event input i sets its status bit (bit i for i<10, bit i+6 for i=10,11). The bit stays set until software clears it.
- R3: A write to the status low half (address 0) clears each low-half status bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged.
- R4: A write to the status high half (address 1) acts only on bits 31..16. A write to the low half never changes the high half.
- R5: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit is set afterwards.
- R6: irq_o goes high one clock after a status bit in positions 0..9, 16 or 17 is set while its mask bit is 0, and stays low while every such set bit is masked. A mask bit of 1 blocks its source.
- R7: The mask low half (address 2) and mask high half (address 3) are written and read back independently. A write to one half leaves the other half unchanged.
- R8: Status bit 18 reads the current write-protect input and bit 19 reads the current command-busy input. Neither bit is sticky, and writes do not affect either.
- R9: A read with bus_rd_i high presents the selected half on bus_rdata_o one clock later. Addresses: 0 status low, 1 status high, 2 mask low, 3 mask high.
- R10: Status bits 10..15 and 20..31 always read 0, even after every event has fired and after writes of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse_i | input | 12 | One-cycle event pulses, one per sticky source |
| wp_lvl_i | input | 1 | Write-protect level, shown live in status bit 18 |
| cmd_busy_i | input | 1 | Command-busy level, shown live in status bit 19 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register half select |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid one clock after the read strobe |
| irq_o | output | 1 | Interrupt request, high while an unmasked source is pending |

## Verification
The collision that matters is an event pulse and a software clearing write landing on the status register in the same clock. The bench provokes it by driving a status write of all zeros in the very cycle that an event pulse is applied. This is done twice: once with the target bit clear beforehand and once with it already set. A readback must then show the event bit still set and every other low-half bit cleared. A second overlap is a mask or acknowledge write while the interrupt is high. Here the bench checks that irq_o falls exactly one clock after the register change and not in the same clock.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

  localparam int HALF_W   = 16;
  localparam int REG_W    = 2 * HALF_W;
  localparam int N_LO_EVT = 10;
  localparam int N_HI_EVT = 2;
  localparam int N_EVT    = N_LO_EVT + N_HI_EVT;
  localparam int WP_BIT   = HALF_W + N_HI_EVT;
  localparam int BUSY_BIT = WP_BIT + 1;

  typedef enum logic [1:0] {
    SEL_ST_LO = 2'd0,
    SEL_ST_HI = 2'd1,
    SEL_MK_LO = 2'd2,
    SEL_MK_HI = 2'd3
  } reg_sel_e;

  function automatic int evt_pos(input int idx);
    return (idx < N_LO_EVT) ? idx : (idx - N_LO_EVT + HALF_W);
  endfunction

  function automatic logic [REG_W-1:0] cap_vec();
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < N_EVT; i++) v[evt_pos(i)] = 1'b1;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] map_evt(input logic [N_EVT-1:0] ev);
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < N_EVT; i++) v[evt_pos(i)] = ev[i];
    return v;
  endfunction

  localparam logic [REG_W-1:0] IRQ_CAP = cap_vec();

endpackage

// File: rtl/sdirq_sticky.sv
module sdirq_sticky
  import sdirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] keep_vec,
  output logic [REG_W-1:0] st_q
);

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (IRQ_CAP[b]) begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n) st_q[b] <= 1'b0;
        else        st_q[b] <= (st_q[b] & keep_vec[b]) | set_vec[b];
      end
    end else begin : g_zero
      assign st_q[b] = 1'b0;
    end
  end

  logic pad_unused;
  assign pad_unused = ^{set_vec & ~IRQ_CAP, keep_vec & ~IRQ_CAP};

endmodule

// File: rtl/sdirq_mask.sv
module sdirq_mask
  import sdirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [REG_W-1:0]  mk_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mk_q <= '1;
    end else begin
      if (wr_lo) mk_q[HALF_W-1:0]     <= wdata;
      if (wr_hi) mk_q[REG_W-1:HALF_W] <= wdata;
    end
  end

endmodule

// File: rtl/sdirq_rdport.sv
module sdirq_rdport
  import sdirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [REG_W-1:0]  st_q,
  input  logic [REG_W-1:0]  mk_q,
  input  logic              wp_lvl,
  input  logic              busy_lvl,
  output logic [HALF_W-1:0] rdata_q
);

  logic [REG_W-1:0]  st_view;
  logic [HALF_W-1:0] rd_mux;

  always_comb begin
    st_view           = st_q;
    st_view[WP_BIT]   = wp_lvl;
    st_view[BUSY_BIT] = busy_lvl;
  end

  always_comb begin
    unique case (sel)
      SEL_ST_LO: rd_mux = st_view[HALF_W-1:0];
      SEL_ST_HI: rd_mux = st_view[REG_W-1:HALF_W];
      SEL_MK_LO: rd_mux = mk_q[HALF_W-1:0];
      default:   rd_mux = mk_q[REG_W-1:HALF_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

endmodule

// File: rtl/sdirq_ctrl.sv
module sdirq_ctrl
  import sdirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  ev_pulse_i,
  input  logic              wp_lvl_i,
  input  logic              cmd_busy_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [HALF_W-1:0] bus_wdata_i,
  output logic [HALF_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  reg_sel_e          sel;
  logic [REG_W-1:0]  set_vec;
  logic [REG_W-1:0]  keep_vec;
  logic [REG_W-1:0]  st_q;
  logic [REG_W-1:0]  mk_q;
  logic              irq_q;

  assign sel     = reg_sel_e'(bus_addr_i);
  assign set_vec = map_evt(ev_pulse_i);

  always_comb begin
    keep_vec = '1;
    if (bus_wr_i && sel == SEL_ST_LO) keep_vec[HALF_W-1:0]     = bus_wdata_i;
    if (bus_wr_i && sel == SEL_ST_HI) keep_vec[REG_W-1:HALF_W] = bus_wdata_i;
  end

  sdirq_sticky u_sticky (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .keep_vec (keep_vec),
    .st_q     (st_q)
  );

  sdirq_mask u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (bus_wr_i && sel == SEL_MK_LO),
    .wr_hi (bus_wr_i && sel == SEL_MK_HI),
    .wdata (bus_wdata_i),
    .mk_q  (mk_q)
  );

  sdirq_rdport u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_rd_i),
    .sel      (sel),
    .st_q     (st_q),
    .mk_q     (mk_q),
    .wp_lvl   (wp_lvl_i),
    .busy_lvl (cmd_busy_i),
    .rdata_q  (bus_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(st_q & ~mk_q & IRQ_CAP);
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/sdirq_chk.sv
module sdirq_chk
  import sdirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [N_EVT-1:0]  ev_pulse_i,
  input logic              bus_wr_i,
  input logic [1:0]        bus_addr_i,
  input logic [HALF_W-1:0] bus_wdata_i,
  input logic [REG_W-1:0]  st_q,
  input logic [REG_W-1:0]  mk_q,
  input logic              irq_o
);

  logic [REG_W-1:0] ev_vec;
  logic             pend;

  assign ev_vec = map_evt(ev_pulse_i);
  assign pend   = |(st_q & ~mk_q & IRQ_CAP);

  // R2
  ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_pulse_i) |=> ((st_q & $past(ev_vec)) == $past(ev_vec)));

  // R3
  lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 2'd0 && ev_pulse_i == '0)
      |=> (st_q[HALF_W-1:0] == ($past(st_q[HALF_W-1:0]) & $past(bus_wdata_i))));

  // R4
  hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 2'd1 && ev_vec[HALF_W-1:0] == '0)
      |=> $stable(st_q[HALF_W-1:0]));

  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> irq_o);

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !irq_o);

  // R7
  mask_hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 2'd3)
      |=> ($stable(mk_q[HALF_W-1:0]) && mk_q[REG_W-1:HALF_W] == $past(bus_wdata_i)));

endmodule

bind sdirq_ctrl sdirq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_pulse_i  (ev_pulse_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .st_q        (st_q),
  .mk_q        (mk_q),
  .irq_o       (irq_o)
);

// File: tb/test_sdirq_ctrl.sv
`timescale 1ns/1ps
module test_sdirq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ev = '0;
  logic        wp = 1'b0;
  logic        busy = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  sdirq_ctrl i_sdirq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_pulse_i  (ev),
    .wp_lvl_i    (wp),
    .cmd_busy_i  (busy),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d, input logic [11:0] e);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d; ev = e;
    @(negedge clk); wr = 1'b0; ev = '0;
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    rd_chk("R1 R9 status lo", 2'd0, 16'h0000);
    rd_chk("R1 R9 status hi", 2'd1, 16'h0000);
    rd_chk("R1 R9 mask lo", 2'd2, 16'hFFFF);
    rd_chk("R1 R9 mask hi", 2'd3, 16'hFFFF);
  endtask

  task automatic t_sticky;
    pulse(12'h028);
    rd_chk("R2 set", 2'd0, 16'h0028);
    repeat (5) @(negedge clk);
    rd_chk("R2 held", 2'd0, 16'h0028);
    chk("R6 all masked", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_clear;
    wr_reg(2'd0, 16'hFFF7, '0);
    rd_chk("R3 zero clears", 2'd0, 16'h0020);
    wr_reg(2'd0, 16'hFFFF, '0);
    rd_chk("R3 ones keep", 2'd0, 16'h0020);
    wr_reg(2'd0, 16'h0000, '0);
    rd_chk("R3 clear all", 2'd0, 16'h0000);
  endtask

  task automatic t_high;
    pulse(12'h400);
    rd_chk("R4 remove bit", 2'd1, 16'h0001);
    wr_reg(2'd0, 16'h0000, '0);
    rd_chk("R4 lo write spares hi", 2'd1, 16'h0001);
    wr_reg(2'd1, 16'hFFFE, '0);
    rd_chk("R4 hi clear", 2'd1, 16'h0000);
    pulse(12'h808);
    wr_reg(2'd1, 16'h0000, '0);
    rd_chk("R4 hi write spares lo", 2'd0, 16'h0008);
    rd_chk("R4 insert cleared", 2'd1, 16'h0000);
    wr_reg(2'd0, 16'h0000, '0);
  endtask

  task automatic t_race;
    pulse(12'h001);
    wr_reg(2'd0, 16'h0000, 12'h002);
    rd_chk("R5 event beats clear", 2'd0, 16'h0002);
    wr_reg(2'd0, 16'h0000, 12'h002);
    rd_chk("R5 set bit survives clear", 2'd0, 16'h0002);
    wr_reg(2'd0, 16'h0000, '0);
    rd_chk("R5 later clear", 2'd0, 16'h0000);
  endtask

  task automatic t_irq;
    wr_reg(2'd2, 16'hFFFE, '0);
    pulse(12'h002);
    @(negedge clk);
    chk("R6 masked source", {15'd0, irq}, 16'h0000);
    pulse(12'h001);
    chk("R6 not same cycle", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    chk("R6 raised", {15'd0, irq}, 16'h0001);
    wr_reg(2'd0, 16'hFFFE, '0);
    chk("R6 held one clock", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    chk("R6 drop on ack", {15'd0, irq}, 16'h0000);
    pulse(12'h001);
    @(negedge clk);
    chk("R6 raised again", {15'd0, irq}, 16'h0001);
    wr_reg(2'd2, 16'hFFFF, '0);
    @(negedge clk);
    chk("R6 drop on mask", {15'd0, irq}, 16'h0000);
    wr_reg(2'd0, 16'h0000, '0);
    wr_reg(2'd3, 16'hFFFE, '0);
    pulse(12'h400);
    @(negedge clk);
    chk("R6 high source", {15'd0, irq}, 16'h0001);
    wr_reg(2'd1, 16'h0000, '0);
    @(negedge clk);
    chk("R6 high ack", {15'd0, irq}, 16'h0000);
    wr_reg(2'd3, 16'hFFFF, '0);
  endtask

  task automatic t_mask_halves;
    wr_reg(2'd3, 16'h1234, '0);
    rd_chk("R7 mask hi", 2'd3, 16'h1234);
    rd_chk("R7 mask lo kept", 2'd2, 16'hFFFF);
    wr_reg(2'd2, 16'h00F0, '0);
    rd_chk("R7 mask lo", 2'd2, 16'h00F0);
    rd_chk("R7 mask hi kept", 2'd3, 16'h1234);
    wr_reg(2'd2, 16'hFFFF, '0);
    wr_reg(2'd3, 16'hFFFF, '0);
  endtask

  task automatic t_live;
    @(negedge clk); wp = 1'b1; busy = 1'b1;
    rd_chk("R8 both live", 2'd1, 16'h000C);
    wr_reg(2'd1, 16'h0000, '0);
    rd_chk("R8 write ignored", 2'd1, 16'h000C);
    @(negedge clk); wp = 1'b0;
    rd_chk("R8 busy only", 2'd1, 16'h0008);
    @(negedge clk); busy = 1'b0;
    rd_chk("R8 not sticky", 2'd1, 16'h0000);
  endtask

  task automatic t_unimpl;
    pulse(12'h3FF);
    rd_chk("R10 low events", 2'd0, 16'h03FF);
    wr_reg(2'd0, 16'hFFFF, '0);
    rd_chk("R10 ones no effect", 2'd0, 16'h03FF);
    pulse(12'hC00);
    wr_reg(2'd1, 16'hFFFF, '0);
    rd_chk("R10 high unused zero", 2'd1, 16'h0003);
    wr_reg(2'd0, 16'h0000, '0);
    wr_reg(2'd1, 16'h0000, '0);
    rd_chk("R10 cleared", 2'd0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_clear();
    t_high();
    t_race();
    t_irq();
    t_mask_halves();
    t_live();
    t_unimpl();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule